// File: doc/BRIEF.md
# SPI Command Engine with Shared Byte Buffer

This block is a SPI host that runs one half-duplex command per software request. Software programs a byte-wide register file: an opcode byte, the number of payload bytes to send after that opcode, the number of response bytes to collect, a chip-select index, and the payload itself, placed in a 71-byte buffer. A write that sets the start bit launches the transaction. The engine drives the selected chip select low and shifts out the opcode and then the payload. It then clocks in the requested response bytes and writes them into the same buffer, directly after the last payload byte. Software polls a busy flag and then reads the response from the buffer.

The SPI side runs in mode 0, most significant bit first. SCLK idles low. MOSI changes after a falling edge and MISO is sampled on a rising edge. Each SCLK half period lasts `HALF_DIV` system clocks. Host reads return data one clock after the address is presented.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, all four chip selects are high, SCLK and MOSI are low, and the status bytes at 0x4C and 0x4F both read 0.
- R2: The register at 0x45 (opcode), 0x48 (send count), 0x4B (receive count) and the low two bits of 0x1D (chip-select index) read back the value last written.
- R3: A write to 0x47 with bit 7 set starts a transaction if send count plus receive count is at most 71. Bit 7 of byte 0x4F (bit 31 of the status word at 0x4C) reads 1 from then until the transaction ends, and 0 afterwards.
- R4: On MOSI the engine sends the opcode first, then the send-count bytes taken from buffer offsets 0x80, 0x81 and upward. Every byte goes out MSB first, with MOSI changing only while SCLK is low.
- R5: Received byte k (counting from 0) is stored at buffer offset 0x80 + send count + k. Each byte is assembled MSB first from MISO, sampled on SCLK rising edges.
- R6: Reception starts only after the last sent bit. MOSI is 0 for every receive bit. A receive count of 0 ends the transaction after the send phase.
- R7: During a transaction, only the chip select whose index is in 0x1D[1:0] is low, and it stays low for every SCLK edge. The other chip selects stay high.
- R8: If send count plus receive count exceeds 71, no transaction starts: the chip selects stay high and busy stays 0. Bit 0 of byte 0x4C is set and stays set until the next start that is accepted.
- R9: A start write while a transaction is running has no effect. No extra bytes are clocked, and the engine is idle once the running transaction ends.
- R10: Host writes to the buffer while busy are discarded.
- R11: While idle, SCLK and MOSI stay low and all chip selects stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for the address presented one clock earlier |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Serial data from host to device |
| spi_miso | input | 1 | Serial data from device to host |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
If the sequencer's byte index or phase is wrong, the effect shows on MOSI within the byte that follows: a payload byte is missing, repeated or swapped, or a non-zero bit appears in the receive phase. The scoreboard compares every byte as it completes, so such a fault is caught within eight SCLK periods. A wrong receive write pointer does not show on the wires. It only shows when the buffer is read back after busy drops, so the bench reads back every response byte at its expected offset. A chip-select or busy fault shows on every SCLK edge, and the bound checker watches those lines continuously.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] ADDR_CSSEL  = 8'h1D;
  localparam logic [7:0] ADDR_OPCODE = 8'h45;
  localparam logic [7:0] ADDR_GO     = 8'h47;
  localparam logic [7:0] ADDR_TXCNT  = 8'h48;
  localparam logic [7:0] ADDR_RXCNT  = 8'h4B;
  localparam logic [7:0] ADDR_STAT0  = 8'h4C;
  localparam logic [7:0] ADDR_STAT3  = 8'h4F;
  localparam logic [7:0] ADDR_BUF    = 8'h80;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_FETCH,
    SQ_TXWAIT,
    SQ_RXSTART,
    SQ_RXWAIT,
    SQ_TAIL
  } seq_state_t;
endpackage

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
  parameter int DEPTH = 71,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic [AW-1:0] host_addr,
  output logic [7:0]    host_rdata,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] eng_addr,
  output logic [7:0]    eng_rdata
);
  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    host_rdata <= mem[host_addr];
    eng_rdata  <= mem[eng_addr];
  end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          run;
  logic [DW-1:0] div;
  logic [2:0]    bitc;
  logic [7:0]    tsh;
  logic [7:0]    rsh;

  assign rx_byte = rsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      div  <= '0;
      bitc <= '0;
      tsh  <= '0;
      rsh  <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run  <= 1'b1;
          tsh  <= tx_byte;
          mosi <= tx_byte[7];
          div  <= '0;
          bitc <= '0;
        end
      end else if (div == DIV_LAST) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rsh  <= {rsh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitc == 3'd7) begin
            run  <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            bitc <= bitc + 3'd1;
            tsh  <= {tsh[6:0], 1'b0};
            mosi <= tsh[6];
          end
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int AW = 7,
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [7:0]     cfg_op,
  input  logic [7:0]     cfg_tx,
  input  logic [7:0]     cfg_rx,
  input  logic [1:0]     cfg_cs,
  input  logic [7:0]     rd_data,
  input  logic           sh_done,
  input  logic [7:0]     sh_rx,
  output logic           busy,
  output logic [NCS-1:0] cs_n,
  output logic [AW-1:0]  rd_addr,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [7:0]     wr_data,
  output logic           sh_start,
  output logic [7:0]     sh_tx
);
  seq_state_t state;
  logic [7:0] op_q, tx_n, rx_n, tx_idx, rx_idx;

  assign busy    = (state != SQ_IDLE);
  assign rd_addr = tx_idx[AW-1:0];
  assign wr_addr = AW'(tx_n + rx_idx);
  assign wr_data = sh_rx;
  assign wr_en   = (state == SQ_RXWAIT) && sh_done;

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = 8'h00;
    unique case (state)
      SQ_LEAD:    begin sh_start = 1'b1; sh_tx = op_q;    end
      SQ_FETCH:   begin sh_start = 1'b1; sh_tx = rd_data; end
      SQ_RXSTART: begin sh_start = 1'b1; sh_tx = 8'h00;   end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      op_q   <= '0;
      tx_n   <= '0;
      rx_n   <= '0;
      tx_idx <= '0;
      rx_idx <= '0;
      cs_n   <= '1;
    end else begin
      unique case (state)
        SQ_IDLE: if (go) begin
          op_q   <= cfg_op;
          tx_n   <= cfg_tx;
          rx_n   <= cfg_rx;
          tx_idx <= '0;
          rx_idx <= '0;
          cs_n   <= ~(NCS'(1) << cfg_cs);
          state  <= SQ_LEAD;
        end
        SQ_LEAD:  state <= SQ_TXWAIT;
        SQ_FETCH: begin
          tx_idx <= tx_idx + 8'd1;
          state  <= SQ_TXWAIT;
        end
        SQ_TXWAIT: if (sh_done) begin
          if (tx_idx < tx_n)     state <= SQ_FETCH;
          else if (rx_n != '0)   state <= SQ_RXSTART;
          else                   state <= SQ_TAIL;
        end
        SQ_RXSTART: state <= SQ_RXWAIT;
        SQ_RXWAIT: if (sh_done) begin
          if (rx_idx + 8'd1 == rx_n) state <= SQ_TAIL;
          else begin
            rx_idx <= rx_idx + 8'd1;
            state  <= SQ_RXSTART;
          end
        end
        SQ_TAIL: begin
          cs_n  <= '1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 71,
  parameter int HALF_DIV  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic [3:0] spi_cs_n
);
  localparam int AW  = $clog2(BUF_DEPTH);
  localparam int NCS = 4;

  logic [7:0] op_r, tx_r, rx_r;
  logic [1:0] cs_r;
  logic       err_q, busy, start_req, too_long, go;
  logic       in_buf, in_buf_q;
  logic [7:0] reg_rd_q, buf_host_rd, buf_eng_rd;
  logic [AW-1:0] host_idx, eng_rd_addr, eng_wr_addr;
  logic       eng_we;
  logic [7:0] eng_wdata;
  logic       sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic       buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0] buf_wdata;

  assign in_buf    = reg_addr[7] && ({1'b0, reg_addr[6:0]} < 8'(BUF_DEPTH));
  assign host_idx  = in_buf ? AW'(reg_addr[6:0]) : '0;
  assign start_req = reg_we && (reg_addr == ADDR_GO) && reg_wdata[7];
  assign too_long  = ({1'b0, tx_r} + {1'b0, rx_r}) > 9'(BUF_DEPTH);
  assign go        = start_req && !busy && !too_long;

  assign buf_we    = eng_we || (reg_we && in_buf && !busy);
  assign buf_waddr = eng_we ? eng_wr_addr : host_idx;
  assign buf_wdata = eng_we ? eng_wdata : reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_r  <= '0;
      tx_r  <= '0;
      rx_r  <= '0;
      cs_r  <= '0;
      err_q <= 1'b0;
    end else begin
      if (reg_we) begin
        unique case (reg_addr)
          ADDR_OPCODE: op_r <= reg_wdata;
          ADDR_TXCNT:  tx_r <= reg_wdata;
          ADDR_RXCNT:  rx_r <= reg_wdata;
          ADDR_CSSEL:  cs_r <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (start_req && !busy) err_q <= too_long;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      in_buf_q <= 1'b0;
    end else begin
      in_buf_q <= in_buf;
      unique case (reg_addr)
        ADDR_CSSEL:  reg_rd_q <= {6'b0, cs_r};
        ADDR_OPCODE: reg_rd_q <= op_r;
        ADDR_TXCNT:  reg_rd_q <= tx_r;
        ADDR_RXCNT:  reg_rd_q <= rx_r;
        ADDR_STAT0:  reg_rd_q <= {7'b0, err_q};
        ADDR_STAT3:  reg_rd_q <= {busy, 7'b0};
        default:     reg_rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata = in_buf_q ? buf_host_rd : reg_rd_q;

  spi_cmd_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk(clk), .host_addr(host_idx), .host_rdata(buf_host_rd),
    .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(buf_wdata),
    .eng_addr(eng_rd_addr), .eng_rdata(buf_eng_rd)
  );

  spi_cmd_seq #(.AW(AW), .NCS(NCS)) u_seq (
    .clk(clk), .rst(rst), .go(go),
    .cfg_op(op_r), .cfg_tx(tx_r), .cfg_rx(rx_r), .cfg_cs(cs_r),
    .rd_data(buf_eng_rd), .sh_done(sh_done), .sh_rx(sh_rx),
    .busy(busy), .cs_n(spi_cs_n), .rd_addr(eng_rd_addr),
    .wr_en(eng_we), .wr_addr(eng_wr_addr), .wr_data(eng_wdata),
    .sh_start(sh_start), .sh_tx(sh_tx)
  );

  spi_cmd_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .done(sh_done), .rx_byte(sh_rx)
  );
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [3:0] cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       err,
  input logic       start_req
);
  // R7
  cs_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));
  // R11
  idle_cs_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> cs_n == 4'hF);
  // R11
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> (!sclk && !mosi));
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(err) |-> $past(start_req && !busy));
  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start_req));
  // R4
  mosi_low_clk_chk: assert property (@(posedge clk) disable iff (rst) sclk |-> $stable(mosi));
endmodule

bind spi_cmd_engine spi_cmd_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .mosi(spi_mosi), .err(err_q), .start_req(start_req)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q [$];
  logic [3:0] exp_cs = 4'hF;
  logic [7:0] mon_sh = '0;
  int mon_bits = 0;
  int sbit = 0;
  logic [7:0] rd_v;
  logic [7:0] pay [0:70];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_engine dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  function automatic logic [7:0] resp(input int k);
    return 8'h3C ^ 8'(k * 8'h55) ^ 8'(k >> 2);
  endfunction

  // device model: counts bits since chip select went low, shifts on falling edge
  wire cs_idle = &spi_cs_n;
  always @(negedge spi_sclk or posedge cs_idle) begin
    if (cs_idle) sbit <= 0;
    else sbit <= sbit + 1;
  end
  always_comb begin
    logic [7:0] b;
    b = resp(sbit >> 3);
    spi_miso = b[7 - (sbit & 7)];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: assemble bytes on rising SCLK and compare against the scoreboard
  always @(posedge spi_sclk) begin
    mon_sh = {mon_sh[6:0], spi_mosi};
    mon_bits++;
    if (mon_bits == 8) begin
      mon_bits = 0;
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected byte", {24'b0, mon_sh}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(mon_sh == e, "R4/R6 mosi byte", {24'b0, mon_sh}, {24'b0, e});
        chk(spi_cs_n == exp_cs, "R7 chip select", {28'b0, spi_cs_n}, {28'b0, exp_cs});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin rd(8'h4F, s); n++; end while (s[7] && n < 20000);
    if (n >= 20000) chk(1'b0, "R3 busy never cleared", {24'b0, s}, 32'h0);
  endtask

  // driver: programs a command and pushes every expected MOSI byte
  task automatic launch(input logic [7:0] op, input int tx, input int rx, input logic [1:0] cs, input logic [7:0] seed);
    wr(8'h1D, {6'b0, cs});
    wr(8'h45, op);
    wr(8'h48, 8'(tx));
    wr(8'h4B, 8'(rx));
    for (int i = 0; i < tx; i++) begin
      pay[i] = seed + 8'(i * 7);
      wr(8'h80 + 8'(i), pay[i]);
    end
    exp_q.push_back(op);
    for (int i = 0; i < tx; i++) exp_q.push_back(pay[i]);
    for (int i = 0; i < rx; i++) exp_q.push_back(8'h00);
    exp_cs = ~(4'b0001 << cs);
    wr(8'h47, 8'h80);
  endtask

  task automatic finish_and_verify(input int tx, input int rx);
    wait_idle();
    chk(exp_q.size() == 0, "R6 byte count", exp_q.size(), 0);
    chk(spi_cs_n == 4'hF, "R11 cs released", {28'b0, spi_cs_n}, 32'hF);
    for (int k = 0; k < rx; k++) begin
      rd(8'h80 + 8'(tx + k), rd_v);
      chk(rd_v == resp(1 + tx + k), "R5 rx placement", {24'b0, rd_v}, {24'b0, resp(1 + tx + k)});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(spi_cs_n == 4'hF && !spi_sclk && !spi_mosi, "R1 pins", {26'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'h3C);
    rd(8'h4C, rd_v); chk(rd_v == 8'h00, "R1 status lo", {24'b0, rd_v}, 0);
    rd(8'h4F, rd_v); chk(rd_v == 8'h00, "R1 status hi", {24'b0, rd_v}, 0);

    // R2 readback
    wr(8'h45, 8'hAB); rd(8'h45, rd_v); chk(rd_v == 8'hAB, "R2 opcode", {24'b0, rd_v}, 32'hAB);
    wr(8'h48, 8'h12); rd(8'h48, rd_v); chk(rd_v == 8'h12, "R2 txcnt", {24'b0, rd_v}, 32'h12);
    wr(8'h4B, 8'h21); rd(8'h4B, rd_v); chk(rd_v == 8'h21, "R2 rxcnt", {24'b0, rd_v}, 32'h21);
    wr(8'h1D, 8'hFE); rd(8'h1D, rd_v); chk(rd_v == 8'h02, "R2 cs index", {24'b0, rd_v}, 32'h02);

    // R3 busy and R6 read-only command
    launch(8'h9F, 0, 3, 2'd0, 8'h00);
    rd(8'h4F, rd_v); chk(rd_v[7] == 1'b1, "R3 busy set", {24'b0, rd_v}, 32'h80);
    finish_and_verify(0, 3);
    rd(8'h4F, rd_v); chk(rd_v[7] == 1'b0, "R3 busy clear", {24'b0, rd_v}, 0);

    // R6 send only, receive count zero
    launch(8'h06, 3, 0, 2'd1, 8'h41);
    finish_and_verify(3, 0);

    // R4 R5 R7 mixed command on chip select 2, plus R9 and R10 while busy
    launch(8'h0B, 5, 4, 2'd2, 8'hC3);
    wr(8'h48, 8'd9);
    wr(8'h47, 8'h80);
    wr(8'h80, 8'hEE);
    finish_and_verify(5, 4);
    rd(8'h80, rd_v); chk(rd_v == pay[0], "R10 buffer write ignored", {24'b0, rd_v}, {24'b0, pay[0]});
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 4'hF && exp_q.size() == 0, "R9 no restart", {28'b0, spi_cs_n}, 32'hF);

    // R8 oversize request rejected
    wr(8'h48, 8'd40); wr(8'h4B, 8'd32); wr(8'h47, 8'h80);
    rd(8'h4C, rd_v); chk(rd_v == 8'h01, "R8 error set", {24'b0, rd_v}, 32'h01);
    rd(8'h4F, rd_v); chk(rd_v == 8'h00, "R8 not busy", {24'b0, rd_v}, 0);
    chk(spi_cs_n == 4'hF, "R8 cs high", {28'b0, spi_cs_n}, 32'hF);

    // R8 error cleared by accepted start at the 71-byte limit on chip select 3
    launch(8'h03, 40, 31, 2'd3, 8'h11);
    rd(8'h4C, rd_v); chk(rd_v == 8'h00, "R8 error cleared", {24'b0, rd_v}, 0);
    finish_and_verify(40, 31);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule